// File: doc/BRIEF.md
# Protection and Configuration Bit Controller

This block is a register-mapped command engine. It keeps two bit vectors: a set of region lock bits and a small set of configuration bits. Software writes one 32-bit command word to the block. The word holds a guard keyword, an opcode and a bit-index argument. The engine then sets or clears a single lock bit or a single configuration bit, or it prepares a readback of either vector. The block does not model a real nonvolatile array. A parameterized busy period stands in for the array's write time. The `verifyFail` input stands in for the array's end-of-operation verify check.

While an operation runs, the ready flag in the status register is low. When the operation ends, the flag rises again, and an interrupt follows it if the mode register enables it. Three cases raise a sticky command error and change nothing:
- a command with a bad keyword;
- a command with an unknown opcode;
- a command whose argument is out of range.

Readback results come out 32 bits per read from the result register, and reads past the stored bits return zero.

The register map uses word addresses on `regAddr`:
- 0 is the mode register.
- 1 is the command register. It is write-only and reads as 0.
- 2 is the status register.
- 3 is the result register.

Top module: `prot_cfg_ctrl`

## Requirements
- R1: A command word holds the keyword in bits [31:24], the argument in bits [23:8] and the opcode in bits [7:0]. A command is accepted only with keyword 0x5A. With any other keyword, status bit 1 (command error) is set, no stored bit changes and ready stays high.
- R2: The opcodes are as follows. Any other opcode sets command error. A set-lock or clear-lock argument of LOCK_BITS or more also sets command error, and nothing changes.

  | Opcode | Operation |
  |--------|-----------|
  | 0x08 | set lock bit |
  | 0x09 | clear lock bit |
  | 0x0A | get lock status |
  | 0x0B | set configuration bit |
  | 0x0C | clear configuration bit |
  | 0x0D | get configuration status |

- R3: After an accepted command, status bit 0 (ready) reads 0 for exactly BUSY_CYCLES cycles and then reads 1. A set or clear takes effect when ready returns.
- R4: A write to the command register while ready is low is ignored. It produces no change and no error.
- R5: For a configuration set or clear, the argument is checked in two steps. An argument of 9 or more sets command error. An argument from CFG_BITS up to 8 is accepted and runs normally, but changes no bit and raises no error.
- R6: After a get-lock command, successive result reads return words k = 0, 1, 2 and so on. Bit n of word k is lock bit 32k+n, and 1 means locked. Every read after word LOCK_BITS/32-1 returns 0.
- R7: The argument of a get-lock command has no effect on the readback.
- R8: After a get-configuration command, the first result read returns the configuration bits zero-extended in bits [CFG_BITS-1:0]. Later reads return 0.
- R9: `verifyFail` is sampled in the last busy cycle. If it is high there, status bit 2 (flash error) is set. The set or clear is still applied.
- R10: Status bits 1 and 2 stay set across later commands until the status register is read. That read returns them set and clears them.
- R11: `irq` is high exactly when mode bit 0 is set and ready is high.
- R12: Reset leaves the block in this state:
  - every lock bit is 0;
  - the configuration bits equal CFG_RESET;
  - ready is 1 and both error bits are 0;
  - mode bit 0 is 0;
  - a result read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; side effects apply on the clock edge |
| regAddr | input | 2 | Word address: 0 mode, 1 command, 2 status, 3 result |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| verifyFail | input | 1 | Verify failure, sampled in the last busy cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with LOCK_BITS = 64, CFG_BITS = 4, BUSY_CYCLES = 3 and CFG_RESET = 4'b0101. Two readback words place the word-ordering rule and the zero-after-exhaustion rule within a few reads, and bit 63 tests the top of the last word. Four configuration bits leave indices 4 to 8 as a silent no-change band and index 9 as the first error. A three-cycle busy period is long enough to land a second command write in the middle of an operation.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

  localparam logic [7:0] CMD_KEY       = 8'h5A;
  localparam int         CFG_ARG_LIMIT = 8;

  typedef enum logic [7:0] {
    OP_SET_LOCK = 8'h08,
    OP_CLR_LOCK = 8'h09,
    OP_GET_LOCK = 8'h0A,
    OP_SET_CFG  = 8'h0B,
    OP_CLR_CFG  = 8'h0C,
    OP_GET_CFG  = 8'h0D
  } opcode_e;

  typedef enum logic [1:0] {
    RA_MODE   = 2'd0,
    RA_CMD    = 2'd1,
    RA_STATUS = 2'd2,
    RA_RESULT = 2'd3
  } regaddr_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic        commit;      // apply the pending set/clear this cycle
    logic        setNotClr;
    logic        targetCfg;   // 1: configuration bit, 0: lock bit
    logic [15:0] bitIdx;
    logic        ptrClear;    // restart readback
    logic        cfgReadback; // readback source chosen at ptrClear
  } dp_strobe_t;

endpackage

// File: rtl/pcc_ctrl.sv
module pcc_ctrl
  import pcc_pkg::*;
#(
  parameter int LOCK_BITS   = 64,
  parameter int CFG_BITS    = 4,
  parameter int BUSY_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic [31:0] cmdWord,
  input  logic        modeWrite,
  input  logic        modeData,
  input  logic        statusRead,
  input  logic        verifyFail,
  output dp_strobe_t  strb,
  output logic        ready,
  output logic        cmdErr,
  output logic        flashErr,
  output logic        irqEn,
  output logic        irq
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]  opField;
  logic [15:0] argField;
  logic        keyOk, opKnown, argErr, changesBit, isSet, isCfg, cfgGet;
  logic        cmdGood, accept, reject, finishing;

  logic [CNT_W-1:0] busyCnt;
  logic             pendApply, pendSet, pendCfg;
  logic [15:0]      pendIdx;

  assign opField  = cmdWord[7:0];
  assign argField = cmdWord[23:8];
  assign keyOk    = (cmdWord[31:24] == CMD_KEY);

  always_comb begin
    opKnown    = 1'b1;
    argErr     = 1'b0;
    changesBit = 1'b0;
    isSet      = 1'b0;
    isCfg      = 1'b0;
    cfgGet     = 1'b0;
    case (opField)
      OP_SET_LOCK, OP_CLR_LOCK: begin
        argErr     = (32'(argField) >= 32'(LOCK_BITS));
        changesBit = 1'b1;
        isSet      = (opField == OP_SET_LOCK);
      end
      OP_SET_CFG, OP_CLR_CFG: begin
        argErr     = (32'(argField) > 32'(CFG_ARG_LIMIT));
        changesBit = (32'(argField) < 32'(CFG_BITS));
        isSet      = (opField == OP_SET_CFG);
        isCfg      = 1'b1;
      end
      OP_GET_LOCK: ;
      OP_GET_CFG:  cfgGet = 1'b1;
      default:     opKnown = 1'b0;
    endcase
  end

  assign ready     = (busyCnt == '0);
  assign cmdGood   = keyOk && opKnown && !argErr;
  assign accept    = cmdWrite && ready && cmdGood;
  assign reject    = cmdWrite && ready && !cmdGood;
  assign finishing = (busyCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt   <= '0;
      pendApply <= 1'b0;
      pendSet   <= 1'b0;
      pendCfg   <= 1'b0;
      pendIdx   <= '0;
    end else if (accept) begin
      busyCnt   <= CNT_W'(BUSY_CYCLES);
      pendApply <= changesBit;
      pendSet   <= isSet;
      pendCfg   <= isCfg;
      pendIdx   <= argField;
    end else if (!ready) begin
      busyCnt   <= busyCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdErr   <= 1'b0;
      flashErr <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (reject)          cmdErr <= 1'b1;
      else if (statusRead) cmdErr <= 1'b0;
      if (finishing && verifyFail) flashErr <= 1'b1;
      else if (statusRead)         flashErr <= 1'b0;
      if (modeWrite) irqEn <= modeData;
    end
  end

  always_comb begin
    strb.commit      = finishing && pendApply;
    strb.setNotClr   = pendSet;
    strb.targetCfg   = pendCfg;
    strb.bitIdx      = pendIdx;
    strb.ptrClear    = accept && (opField == OP_GET_LOCK || cfgGet);
    strb.cfgReadback = cfgGet;
  end

  assign irq = irqEn && ready;

  a_r1_bad_key_keeps_ready: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && ready && cmdWord[31:24] != CMD_KEY) |=> ready);
  a_r3_accept_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !ready);
  a_r4_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrite && !ready) |=> ($stable(pendIdx) && $stable(pendSet) && $stable(pendCfg)));
  a_r10_cmd_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (cmdErr && !statusRead) |=> cmdErr);
  a_r10_flash_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flashErr && !statusRead) |=> flashErr);

endmodule

// File: rtl/pcc_datapath.sv
module pcc_datapath
  import pcc_pkg::*;
#(
  parameter int                LOCK_BITS = 64,
  parameter int                CFG_BITS  = 4,
  parameter logic [CFG_BITS-1:0] CFG_RESET = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  dp_strobe_t  strb,
  input  logic        resultRead,
  output logic [31:0] resultWord
);

  localparam int LOCK_WORDS = LOCK_BITS / 32;
  localparam int PTR_W      = $clog2(LOCK_WORDS + 1);
  localparam int WIDX_W     = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
  localparam int LIDX_W     = $clog2(LOCK_BITS);
  localparam int CIDX_W     = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;

  logic [LOCK_BITS-1:0] lockBits;
  logic [CFG_BITS-1:0]  cfgBits;
  logic [PTR_W-1:0]     readPtr, ptrLimit;
  logic                 cfgMode;
  logic [31:0]          lockWords [LOCK_WORDS];
  logic [LIDX_W-1:0]    lockIdx;
  logic [CIDX_W-1:0]    cfgIdx;
  logic                 unusedIdxBits;

  assign lockIdx       = strb.bitIdx[LIDX_W-1:0];
  assign cfgIdx        = strb.bitIdx[CIDX_W-1:0];
  assign unusedIdxBits = ^strb.bitIdx;

  for (genvar w = 0; w < LOCK_WORDS; w++) begin : g_word
    assign lockWords[w] = lockBits[w*32 +: 32];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits <= '0;
      cfgBits  <= CFG_RESET;
    end else if (strb.commit) begin
      if (strb.targetCfg) cfgBits[cfgIdx]   <= strb.setNotClr;
      else                lockBits[lockIdx] <= strb.setNotClr;
    end
  end

  assign ptrLimit = cfgMode ? PTR_W'(1) : PTR_W'(LOCK_WORDS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readPtr <= PTR_W'(LOCK_WORDS);
      cfgMode <= 1'b0;
    end else if (strb.ptrClear) begin
      readPtr <= '0;
      cfgMode <= strb.cfgReadback;
    end else if (resultRead && readPtr != ptrLimit) begin
      readPtr <= readPtr + PTR_W'(1);
    end
  end

  always_comb begin
    resultWord = '0;
    if (cfgMode) begin
      if (readPtr == '0) resultWord = 32'(cfgBits);
    end else if (readPtr < PTR_W'(LOCK_WORDS)) begin
      resultWord = lockWords[readPtr[WIDX_W-1:0]];
    end
  end

  a_r1_bits_hold_without_commit: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(lockBits) && $stable(cfgBits)));
  a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    readPtr <= PTR_W'(LOCK_WORDS));

endmodule

// File: rtl/prot_cfg_ctrl.sv
module prot_cfg_ctrl
  import pcc_pkg::*;
#(
  parameter int                  LOCK_BITS   = 64,
  parameter int                  CFG_BITS    = 4,
  parameter int                  BUSY_CYCLES = 3,
  parameter logic [CFG_BITS-1:0] CFG_RESET   = 4'b0101
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        verifyFail,
  output logic        irq
);

  dp_strobe_t  strb;
  logic        ready, cmdErr, flashErr, irqEn;
  logic [31:0] resultWord;

  pcc_ctrl #(
    .LOCK_BITS  (LOCK_BITS),
    .CFG_BITS   (CFG_BITS),
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWrite  (regWrEn && regAddr == RA_CMD),
    .cmdWord   (regWrData),
    .modeWrite (regWrEn && regAddr == RA_MODE),
    .modeData  (regWrData[0]),
    .statusRead(regRdEn && regAddr == RA_STATUS),
    .verifyFail(verifyFail),
    .strb      (strb),
    .ready     (ready),
    .cmdErr    (cmdErr),
    .flashErr  (flashErr),
    .irqEn     (irqEn),
    .irq       (irq)
  );

  pcc_datapath #(
    .LOCK_BITS(LOCK_BITS),
    .CFG_BITS (CFG_BITS),
    .CFG_RESET(CFG_RESET)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .resultRead(regRdEn && regAddr == RA_RESULT),
    .resultWord(resultWord)
  );

  always_comb begin
    case (regAddr)
      RA_MODE:   regRdData = {31'b0, irqEn};
      RA_STATUS: regRdData = {29'b0, flashErr, cmdErr, ready};
      RA_RESULT: regRdData = resultWord;
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: tb/prot_cfg_ctrl_tb.sv
module prot_cfg_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 3;
  localparam int NVEC       = 14;

  // {command word, verifyFail, expected status {flashErr, cmdErr, ready}}
  localparam logic [35:0] VEC [NVEC] = '{
    {32'h5A0005_08, 1'b0, 3'b001},  // R3 set lock 5
    {32'h5A0028_08, 1'b0, 3'b001},  // R6 set lock 40
    {32'h5A003F_08, 1'b0, 3'b001},  // R6 set lock 63
    {32'h5A0005_09, 1'b0, 3'b001},  // R2 clear lock 5
    {32'h5B0007_08, 1'b0, 3'b011},  // R1 bad keyword
    {32'h5A0040_08, 1'b0, 3'b011},  // R2 lock index out of range
    {32'h5A0001_0B, 1'b0, 3'b001},  // R2 set cfg 1
    {32'h5A0000_0C, 1'b0, 3'b001},  // R2 clear cfg 0
    {32'h5A0006_0B, 1'b0, 3'b001},  // R5 unimplemented index, no error
    {32'h5A0009_0B, 1'b0, 3'b011},  // R5 index 9 -> error
    {32'h5A0008_0B, 1'b0, 3'b001},  // R5 index 8 -> no error
    {32'h5A0002_0C, 1'b1, 3'b101},  // R9 verify failure
    {32'h5A0000_33, 1'b0, 3'b011},  // R2 unknown opcode
    {32'h5AFFFF_0A, 1'b0, 3'b001}   // R7 get lock, odd argument
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        verifyFail = 1'b0;
  logic        irq;

  int          nChecks = 0, nFail = 0;
  logic [63:0] lockModel = '0;
  logic [3:0]  cfgModel = 4'b0101;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_cfg_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .verifyFail(verifyFail), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // Bench model of the stored bits, from the requirements
  task automatic modelApply(input logic [31:0] c);
    logic [15:0] arg;
    arg = c[23:8];
    if (c[31:24] == 8'h5A) begin
      case (c[7:0])
        8'h08: if (arg < 64) lockModel[arg[5:0]] = 1'b1;
        8'h09: if (arg < 64) lockModel[arg[5:0]] = 1'b0;
        8'h0B: if (arg < 4)  cfgModel[arg[1:0]]  = 1'b1;
        8'h0C: if (arg < 4)  cfgModel[arg[1:0]]  = 1'b0;
        default: ;
      endcase
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected <20000", cyc);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(2'd2, d); check("R12 status", d, 32'h1);
    rd(2'd0, d); check("R12 mode", d, 32'h0);
    check("R12 irq", {31'b0, irq}, 32'h0);
    rd(2'd3, d); check("R12 result", d, 32'h0);
    wr(2'd1, 32'h5A0000_0D);
    repeat (BUSY) @(negedge clk);
    rd(2'd3, d); check("R12 cfg reset", d, 32'h5);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      verifyFail = VEC[i][3];
      wr(2'd1, VEC[i][35:4]);
      check("R3 ready after write", {31'b0, regRdData[0] | 1'b0}, {31'b0, 1'b0} | 32'(0));
      regAddr = 2'd2; #1;
      check("R3 ready after write", {31'b0, regRdData[0]}, {31'b0, VEC[i][1]});
      repeat (BUSY) @(negedge clk);
      verifyFail = 1'b0;
      rd(2'd2, d);
      check("R1/R2/R3/R5/R9 status", d, {29'b0, VEC[i][2:0]});
      modelApply(VEC[i][35:4]);
    end

    // R6/R7 lock readback (get lock issued last in table)
    rd(2'd3, d); check("R6 word0", d, lockModel[31:0]);
    rd(2'd3, d); check("R6 word1", d, lockModel[63:32]);
    check("R6 bits 40 and 63", lockModel[63:32], 32'h8000_0100);
    rd(2'd3, d); check("R6 past end", d, 32'h0);
    rd(2'd3, d); check("R6 past end again", d, 32'h0);

    // R8 configuration readback
    wr(2'd1, 32'h5A0000_0D);
    repeat (BUSY) @(negedge clk);
    rd(2'd3, d); check("R8 cfg word", d, {28'b0, cfgModel});
    check("R8 cfg value", {28'b0, cfgModel}, 32'h2);
    rd(2'd3, d); check("R8 past end", d, 32'h0);

    // R4 write while busy is ignored
    wr(2'd1, 32'h5A0001_08);
    wr(2'd1, 32'h5A0002_08);
    modelApply(32'h5A0001_08);
    repeat (BUSY) @(negedge clk);
    rd(2'd2, d); check("R4 no error", d, 32'h1);
    wr(2'd1, 32'h5A0000_0A);
    repeat (BUSY) @(negedge clk);
    rd(2'd3, d); check("R4 only first applied", d, 32'h0000_0002);

    // R10 sticky errors
    wr(2'd1, 32'h000000_08);
    wr(2'd1, 32'h5A0003_0B);
    repeat (BUSY) @(negedge clk);
    rd(2'd2, d); check("R10 held across command", d, 32'h3);
    rd(2'd2, d); check("R10 cleared by read", d, 32'h1);

    // R11 interrupt
    wr(2'd0, 32'h1);
    check("R11 irq enabled ready", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'h5A0003_0C);
    check("R11 irq low while busy", {31'b0, irq}, 32'h0);
    repeat (BUSY) @(negedge clk);
    check("R11 irq at done", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0);
    check("R11 irq disabled", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule